// File: doc/BRIEF.md
# UART Transmit/Receive FIFO Pair with Threshold Requests

This block buffers bytes on both sides of a serial port. It holds a 64-entry byte queue for outgoing data and another for incoming data. On the transmit side the host pushes and the serializer pops. On the receive side the deserializer pushes and the host pops. Each queue reports its occupancy as a count field plus a separate full flag in a 16-bit status word. Each queue also drives a level-sensitive request when its programmed threshold condition holds, so an interrupt controller can service the queue in bursts.

An 8-bit control word is loaded through a write strobe and can be read back. It selects FIFO mode or single-byte holding mode, sets the two threshold selections, and carries two flush bits that clear themselves. Each queue has a three-state occupancy machine with states CH_EMPTY, CH_PART and CH_FULL. Its transitions are fill (CH_EMPTY to CH_PART), top-up (CH_PART to CH_FULL, or CH_EMPTY to CH_FULL in holding mode), drain (CH_FULL to CH_PART, or CH_FULL to CH_EMPTY in holding mode), empty-out (CH_PART to CH_EMPTY) and flush (any state to CH_EMPTY). The control word has a two-state machine with states CT_STEADY and CT_FLUSH. A write that requests a flush arms CT_FLUSH. In the next cycle the flush is applied and the machine retires to CT_STEADY, unless a new flush is requested.

Top module: `uart_fifo_pair`

## Requirements
- R1: After reset the control word reads 0x00 (holding mode), the status word is 0x0000, tx_req is 1, rx_req is 0 and rx_overrun is 0.
- R2: Control bit 0 is the FIFO enable, bit 1 is the receive flush, bit 2 is the transmit flush, bits 5:4 are the receive threshold select and bits 7:6 are the transmit threshold select. Bit 3 always reads 0. A flush bit reads 1 for exactly one cycle after the write and then reads 0 unless it is written again.
- R3: Status bits 5:0 hold the receive count, bit 6 the receive full flag, bits 13:8 the transmit count and bit 14 the transmit full flag. Bits 7 and 15 read 0. A full flag is set only when the queue holds its capacity, and the count field then reads 0.
- R4: In FIFO mode each queue holds 64 bytes and returns them in push order.
- R5: In holding mode (bit 0 clear) each queue holds one byte, and a held byte shows full set with count 0.
- R6: In FIFO mode tx_req is 1 while transmit occupancy is at or below 0, 16, 32 or 48 for select values 00, 01, 10 or 11. In holding mode tx_req is 1 while the transmit side is empty.
- R7: In FIFO mode rx_req is 1 while receive occupancy is at or above 1, 8, 16 or 32 for select values 00, 01, 10 or 11. In holding mode rx_req is 1 while a receive byte is held.
- R8: In the cycle after a flush bit is written, the selected queue becomes empty. A push or pop on that queue in that cycle is discarded, and a receive flush clears rx_overrun.
- R9: A control write that changes bit 0 flushes both queues in the following cycle and shows both flush bits for that one cycle.
- R10: A push to a full queue (without a pop in the same cycle) is dropped. On the receive side it sets rx_overrun, which stays set until a receive flush.
- R11: A pop presents its byte on the pop data output after the clock edge. A pop from an empty queue leaves the pop data and the status unchanged.
- R12: A push and a pop in the same cycle on a queue holding at least one byte leave its occupancy unchanged. This holds also when the queue is full, and no overrun is raised in that case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word write value |
| ctrl_rdata | output | 8 | Control word readback |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_push_data | input | 8 | Byte to push into the transmit queue |
| tx_pop | input | 1 | Pop a byte from the transmit queue |
| tx_pop_data | output | 8 | Last byte popped from the transmit queue |
| rx_push | input | 1 | Push a byte into the receive queue |
| rx_push_data | input | 8 | Byte to push into the receive queue |
| rx_pop | input | 1 | Pop a byte from the receive queue |
| rx_pop_data | output | 8 | Last byte popped from the receive queue |
| fifo_status | output | 16 | Counts and full flags of both queues |
| tx_req | output | 1 | Transmit threshold request |
| rx_req | output | 1 | Receive threshold request |
| rx_overrun | output | 1 | Sticky receive overrun flag |

## Verification
Two pairs of functions can meet in one cycle. The first is a pop freeing the slot that a push needs on a full queue. The second is a flush landing in the same cycle as a push. The bench fills the receive queue to 64 bytes and then raises push and pop together. It expects the full flag to stay set, the oldest byte to appear on the pop output and rx_overrun to stay clear. It also writes a receive flush and holds a push through the following cycle. It then expects an empty queue, proving that the flush wins and the pushed byte is discarded.

// File: rtl/ufp_pkg.sv
package ufp_pkg;

    typedef enum logic [1:0] {
        CH_EMPTY = 2'd0,
        CH_PART  = 2'd1,
        CH_FULL  = 2'd2
    } chan_state_t;

    typedef enum logic {
        CT_STEADY = 1'b0,
        CT_FLUSH  = 1'b1
    } ctl_state_t;

    typedef struct packed {
        logic [1:0] tx_trig;
        logic [1:0] rx_trig;
        logic       rsv;
        logic       tx_flush;
        logic       rx_flush;
        logic       fifo_en;
    } ctrl_word_t;

    // transmit threshold: quarters of the depth (0, 1/4, 1/2, 3/4)
    function automatic int unsigned tx_level(input logic [1:0] sel, input int unsigned depth);
        return (depth / 4) * int'(sel);
    endfunction

    // receive threshold: one byte, then eighth / quarter / half of the depth
    function automatic int unsigned rx_level(input logic [1:0] sel, input int unsigned depth);
        if (sel == 2'b00)
            return 1;
        return (depth / 8) << (int'(sel) - 1);
    endfunction

endpackage

// File: rtl/ufp_ctrl_reg.sv
module ufp_ctrl_reg
    import ufp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output ctrl_word_t word,
    output logic       rx_flush,
    output logic       tx_flush
);

    ctl_state_t state_q, state_d;
    ctrl_word_t word_q, word_d;

    always_comb begin
        word_d = word_q;
        unique case (state_q)
            CT_STEADY: ;
            CT_FLUSH: begin
                word_d.rx_flush = 1'b0;
                word_d.tx_flush = 1'b0;
            end
            default: ;
        endcase
        if (wr) begin
            word_d     = ctrl_word_t'(wdata);
            word_d.rsv = 1'b0;
            if (wdata[0] != word_q.fifo_en) begin
                word_d.rx_flush = 1'b1;
                word_d.tx_flush = 1'b1;
            end
        end
        state_d = (word_d.rx_flush || word_d.tx_flush) ? CT_FLUSH : CT_STEADY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CT_STEADY;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            word_q  <= word_d;
        end
    end

    always_comb begin
        word     = word_q;
        rx_flush = (state_q == CT_FLUSH) && word_q.rx_flush;
        tx_flush = (state_q == CT_FLUSH) && word_q.tx_flush;
    end

endmodule

// File: rtl/ufp_fifo_chan.sv
module ufp_fifo_chan
    import ufp_pkg::*;
#(
    parameter  int DEPTH = 64,
    parameter  int WIDTH = 8,
    parameter  bit IS_RX = 1'b0,
    localparam int AW    = $clog2(DEPTH),
    localparam int OW    = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_en,
    input  logic [1:0]       trig_sel,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] pop_data,
    output logic [AW-1:0]    cnt_field,
    output logic             full,
    output logic             req
);

    chan_state_t      state_q, state_d;
    logic [OW-1:0]    occ_q, occ_d, cap, level;
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] pop_data_q;
    logic             can_push, can_pop, do_push, do_pop;

    // acceptance and next occupancy
    always_comb begin
        can_push = 1'b0;
        can_pop  = 1'b0;
        unique case (state_q)
            CH_EMPTY: begin
                can_push = 1'b1;
                can_pop  = 1'b0;
            end
            CH_PART: begin
                can_push = 1'b1;
                can_pop  = 1'b1;
            end
            CH_FULL: begin
                can_pop  = 1'b1;
                can_push = pop;
            end
            default: ;
        endcase
        do_push = push && can_push && !flush;
        do_pop  = pop && can_pop && !flush;
        cap     = fifo_en ? OW'(DEPTH) : OW'(1);
        if (flush)
            occ_d = '0;
        else
            occ_d = occ_q + OW'(do_push) - OW'(do_pop);
        if (occ_d == '0)
            state_d = CH_EMPTY;
        else if (occ_d >= cap)
            state_d = CH_FULL;
        else
            state_d = CH_PART;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= CH_EMPTY;
            occ_q      <= '0;
            wr_ptr_q   <= '0;
            rd_ptr_q   <= '0;
            pop_data_q <= '0;
        end else begin
            state_q <= state_d;
            occ_q   <= occ_d;
            if (flush) begin
                wr_ptr_q <= '0;
                rd_ptr_q <= '0;
            end else begin
                if (do_push)
                    wr_ptr_q <= wr_ptr_q + AW'(1);
                if (do_pop) begin
                    rd_ptr_q   <= rd_ptr_q + AW'(1);
                    pop_data_q <= mem[rd_ptr_q];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr_q] <= push_data;
    end

    // outputs
    always_comb begin
        full      = (state_q == CH_FULL);
        cnt_field = full ? '0 : occ_q[AW-1:0];
        pop_data  = pop_data_q;
    end

    generate
        if (IS_RX) begin : g_rx_req
            always_comb begin
                level = OW'(rx_level(trig_sel, DEPTH));
                req   = fifo_en ? (occ_q >= level) : (occ_q != '0);
            end
        end else begin : g_tx_req
            always_comb begin
                level = OW'(tx_level(trig_sel, DEPTH));
                req   = fifo_en ? (occ_q <= level) : (occ_q == '0);
            end
        end
    endgenerate

endmodule

// File: rtl/ufp_overrun.sv
module ufp_overrun (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic push,
    input  logic pop,
    input  logic full,
    output logic overrun
);

    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (flush)
            flag_q <= 1'b0;
        else if (push && full && !pop)
            flag_q <= 1'b1;
    end

    assign overrun = flag_q;

endmodule

// File: rtl/uart_fifo_pair.sv
module uart_fifo_pair
    import ufp_pkg::*;
#(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic [7:0]    ctrl_wdata,
    output logic [7:0]    ctrl_rdata,
    input  logic          tx_push,
    input  logic [7:0]    tx_push_data,
    input  logic          tx_pop,
    output logic [7:0]    tx_pop_data,
    input  logic          rx_push,
    input  logic [7:0]    rx_push_data,
    input  logic          rx_pop,
    output logic [7:0]    rx_pop_data,
    output logic [2*AW+3:0] fifo_status,
    output logic          tx_req,
    output logic          rx_req,
    output logic          rx_overrun
);

    ctrl_word_t    word;
    logic          rx_flush, tx_flush;
    logic [AW-1:0] rx_cnt, tx_cnt;
    logic          rx_full, tx_full;

    ufp_ctrl_reg u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctrl_wr),
        .wdata    (ctrl_wdata),
        .word     (word),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    ufp_fifo_chan #(.DEPTH(DEPTH), .WIDTH(8), .IS_RX(1'b0)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (word.fifo_en),
        .trig_sel  (word.tx_trig),
        .flush     (tx_flush),
        .push      (tx_push),
        .push_data (tx_push_data),
        .pop       (tx_pop),
        .pop_data  (tx_pop_data),
        .cnt_field (tx_cnt),
        .full      (tx_full),
        .req       (tx_req)
    );

    ufp_fifo_chan #(.DEPTH(DEPTH), .WIDTH(8), .IS_RX(1'b1)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_en   (word.fifo_en),
        .trig_sel  (word.rx_trig),
        .flush     (rx_flush),
        .push      (rx_push),
        .push_data (rx_push_data),
        .pop       (rx_pop),
        .pop_data  (rx_pop_data),
        .cnt_field (rx_cnt),
        .full      (rx_full),
        .req       (rx_req)
    );

    ufp_overrun u_ovr (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (rx_flush),
        .push    (rx_push),
        .pop     (rx_pop),
        .full    (rx_full),
        .overrun (rx_overrun)
    );

    assign ctrl_rdata  = word;
    assign fifo_status = {1'b0, tx_full, tx_cnt, 1'b0, rx_full, rx_cnt};

endmodule

// File: rtl/ufp_checker.sv
module ufp_checker #(
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ctrl_wr,
    input logic [7:0]      ctrl_wdata,
    input logic [7:0]      ctrl_rdata,
    input logic            rx_push,
    input logic            rx_pop,
    input logic [7:0]      rx_pop_data,
    input logic [2*AW+3:0] fifo_status,
    input logic            tx_req,
    input logic            rx_overrun
);

    // R2: an armed receive flush bit clears itself when not rewritten
    p_flush_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[1] && !(ctrl_wr && (ctrl_wdata[1] || (ctrl_wdata[0] != ctrl_rdata[0]))))
        |=> !ctrl_rdata[1]);

    // R8: receive flush leaves the receive queue empty
    p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[1] |=> (fifo_status[AW:0] == '0));

    // R10: overrun is sticky until a receive flush
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !ctrl_rdata[1]) |=> rx_overrun);

    // R12: push and pop together on a non-empty receive queue keep occupancy
    p_pushpop_count_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_pop && (fifo_status[AW:0] != '0) && !ctrl_rdata[1])
        |=> $stable(fifo_status[AW:0]));

    // R11: pop from an empty receive queue keeps the pop data
    p_pop_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pop && !rx_push && (fifo_status[AW:0] == '0)) |=> $stable(rx_pop_data));

    // R3: a full flag comes with a zero count field
    p_full_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_status[AW] |-> (fifo_status[AW-1:0] == '0));

    // R6: with the lowest transmit threshold the request means empty
    p_tx_req_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[0] && ctrl_rdata[7:6] == 2'b00)
        |-> (tx_req == (fifo_status[2*AW+1:AW+2] == '0 && !fifo_status[2*AW+2])));

endmodule

bind uart_fifo_pair ufp_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/uart_fifo_pair_test.sv
module uart_fifo_pair_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  ctrl_rdata;
    logic        tx_push = 1'b0;
    logic [7:0]  tx_push_data = '0;
    logic        tx_pop = 1'b0;
    logic [7:0]  tx_pop_data;
    logic        rx_push = 1'b0;
    logic [7:0]  rx_push_data = '0;
    logic        rx_pop = 1'b0;
    logic [7:0]  rx_pop_data;
    logic [15:0] fifo_status;
    logic        tx_req, rx_req, rx_overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_fifo_pair uut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .ctrl_rdata(ctrl_rdata), .tx_push(tx_push), .tx_push_data(tx_push_data),
        .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .rx_push(rx_push),
        .rx_push_data(rx_push_data), .rx_pop(rx_pop), .rx_pop_data(rx_pop_data),
        .fifo_status(fifo_status), .tx_req(tx_req), .rx_req(rx_req),
        .rx_overrun(rx_overrun)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_wr = 1'b1; ctrl_wdata = v;
        tick();
        ctrl_wr = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        rx_push = 1'b1; rx_push_data = b;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_push = 1'b1; tx_push_data = b;
        tick();
        tx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        tick();
        rx_pop = 1'b0;
    endtask

    task automatic pop_tx();
        tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 ctrl", ctrl_rdata, 8'h00);
        chk("R1 status", fifo_status, 16'h0000);
        chk("R1 tx_req", tx_req, 1);
        chk("R1 rx_req", rx_req, 0);
        chk("R1 overrun", rx_overrun, 0);
    endtask

    task automatic t_holding();
        push_rx(8'hA5);
        chk("R5 rx held full/count0", fifo_status[6:0], 7'h40);
        chk("R7 rx_req holding", rx_req, 1);
        push_rx(8'h11);
        chk("R10 overrun set", rx_overrun, 1);
        chk("R10 still one byte", fifo_status[6:0], 7'h40);
        pop_rx();
        chk("R5 rx pop data", rx_pop_data, 8'hA5);
        chk("R5 rx empty", fifo_status[6:0], 7'h00);
        chk("R7 rx_req cleared", rx_req, 0);
        chk("R10 overrun sticky", rx_overrun, 1);
        pop_rx();
        chk("R11 pop empty data", rx_pop_data, 8'hA5);
        push_tx(8'h3C);
        chk("R5 tx held full", fifo_status[14:8], 7'h40);
        chk("R6 tx_req holding busy", tx_req, 0);
        pop_tx();
        chk("R11 tx pop data", tx_pop_data, 8'h3C);
        chk("R6 tx_req holding empty", tx_req, 1);
    endtask

    task automatic t_mode_switch();
        push_rx(8'h77);
        push_tx(8'h78);
        wr_ctrl(8'h01);
        chk("R9 both flush bits shown", ctrl_rdata, 8'h07);
        tick();
        chk("R2 flush bits self-clear", ctrl_rdata, 8'h01);
        chk("R9 both queues flushed", fifo_status, 16'h0000);
        chk("R8 rx flush clears overrun", rx_overrun, 0);
    endtask

    task automatic t_rx_levels();
        wr_ctrl(8'h11);
        chk("R2 readback", ctrl_rdata, 8'h11);
        for (int i = 1; i <= 7; i++) push_rx(8'(i));
        chk("R7 below 8", rx_req, 0);
        chk("R3 rx count 7", fifo_status[6:0], 7'd7);
        push_rx(8'd8);
        chk("R7 at 8", rx_req, 1);
        for (int i = 9; i <= 64; i++) push_rx(8'(i));
        chk("R3 full count0", fifo_status[6:0], 7'h40);
        chk("R3 reserved bits", {fifo_status[15], fifo_status[7]}, 2'b00);
        chk("R10 no overrun at 64", rx_overrun, 0);
        push_rx(8'hEE);
        chk("R10 overrun on 65th", rx_overrun, 1);
        chk("R10 still full", fifo_status[6:0], 7'h40);
        pop_rx();
        chk("R4 first byte", rx_pop_data, 8'd1);
        chk("R3 count 63", fifo_status[6:0], 7'd63);
        for (int i = 2; i <= 64; i++) begin
            pop_rx();
            chk("R4 order", rx_pop_data, 8'(i));
        end
        chk("R7 drained", rx_req, 0);
        pop_rx();
        chk("R11 pop empty data", rx_pop_data, 8'd64);
        chk("R11 pop empty status", fifo_status[6:0], 7'h00);
        wr_ctrl(8'h31);
        for (int i = 0; i < 31; i++) push_rx(8'h20);
        chk("R7 below 32", rx_req, 0);
        push_rx(8'h21);
        chk("R7 at 32", rx_req, 1);
        wr_ctrl(8'h33);
        chk("R2 rx flush bit", ctrl_rdata, 8'h33);
        rx_push = 1'b1; rx_push_data = 8'h99;
        tick();
        rx_push = 1'b0;
        chk("R2 rx flush cleared", ctrl_rdata, 8'h31);
        chk("R8 flushed, push discarded", fifo_status[6:0], 7'h00);
        chk("R8 overrun cleared", rx_overrun, 0);
        wr_ctrl(8'h01);
        push_rx(8'h5A);
        chk("R7 threshold 1", rx_req, 1);
    endtask

    task automatic t_push_pop();
        push_rx(8'h5B);
        rx_push = 1'b1; rx_pop = 1'b1; rx_push_data = 8'h5C;
        tick();
        rx_push = 1'b0; rx_pop = 1'b0;
        chk("R12 count kept", fifo_status[6:0], 7'd2);
        chk("R12 oldest popped", rx_pop_data, 8'h5A);
        wr_ctrl(8'h03);
        tick();
        for (int i = 0; i < 64; i++) push_rx(8'(8'h80 + i));
        chk("R12 full before", fifo_status[6:0], 7'h40);
        rx_push = 1'b1; rx_pop = 1'b1; rx_push_data = 8'hF0;
        tick();
        rx_push = 1'b0; rx_pop = 1'b0;
        chk("R12 still full", fifo_status[6:0], 7'h40);
        chk("R12 no overrun", rx_overrun, 0);
        chk("R12 popped oldest", rx_pop_data, 8'h80);
        wr_ctrl(8'h03);
        tick();
        rx_push = 1'b1; rx_pop = 1'b1; rx_push_data = 8'h44;
        tick();
        rx_push = 1'b0; rx_pop = 1'b0;
        chk("R11 empty pop ignored, push lands", fifo_status[6:0], 7'd1);
        chk("R11 data unchanged", rx_pop_data, 8'h80);
    endtask

    task automatic t_tx_levels();
        wr_ctrl(8'h41);
        chk("R6 empty sel01", tx_req, 1);
        for (int i = 0; i < 16; i++) push_tx(8'(8'h10 + i));
        chk("R6 at 16", tx_req, 1);
        chk("R3 tx count 16", fifo_status[14:8], 7'd16);
        push_tx(8'h30);
        chk("R6 above 16", tx_req, 0);
        wr_ctrl(8'h01);
        chk("R6 sel00 busy", tx_req, 0);
        wr_ctrl(8'h81);
        chk("R6 sel10 below 32", tx_req, 1);
        wr_ctrl(8'hC9);
        chk("R2 reserved bit reads 0", ctrl_rdata, 8'hC1);
        for (int i = 0; i < 31; i++) push_tx(8'h31);
        chk("R6 at 48", tx_req, 1);
        push_tx(8'h32);
        chk("R6 above 48", tx_req, 0);
        pop_tx();
        chk("R4 tx order", tx_pop_data, 8'h10);
        pop_tx();
        chk("R4 tx order 2", tx_pop_data, 8'h11);
        wr_ctrl(8'hC5);
        chk("R2 tx flush bit", ctrl_rdata, 8'hC5);
        tick();
        chk("R2 tx flush cleared", ctrl_rdata, 8'hC1);
        chk("R8 tx flushed", fifo_status[14:8], 7'h00);
        chk("R6 empty after flush", tx_req, 1);
    endtask

    initial begin
        t_reset();
        t_holding();
        t_mode_switch();
        t_rx_levels();
        t_push_pop();
        t_tx_levels();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

endmodule